// File: doc/BRIEF.md
# Multicycle Instruction Sequencer

This block is the control state machine of a small 16-bit, word-addressed processor core with eight general registers, one shared 16-bit bus and an external datapath and memory. It reads the four opcode bits of the instruction register, bit 5 of that register (the immediate/register operand selector), a branch-condition flag computed by the datapath and a memory-ready handshake. From these it drives every control strobe of the datapath: which source may drive the bus, which registers load, the multiplexer selects, the ALU function and the memory enable and write strobes.

Every instruction is carried out as a chain of steps. Two fetch steps are followed by a decode step. Then come the address, operand-read, execute and write-back steps that the opcode needs. Each step asserts its strobes for one cycle, or longer for a memory step that must wait for the memory. The step is always followed by one release cycle in which no strobe is active. Indirect loads and stores make two memory accesses. Trap saves the return address in R7 before it jumps through a vector.

Top module: `instr_sequencer`

## Requirements
- R1: While `rst` is high (synchronous), the only active strobe is `ld_pc`, with `pc_mux`=3 (start address). `pc_start` always carries the START_ADDR parameter. The first cycle after `rst` falls is the first fetch step: `gate_pc`, `ld_mar`, `mem_en` (read) and `ld_mdr`.
- R2: The second fetch step asserts `gate_mdr`, `ld_ir`, `ld_pc` with `pc_mux`=0 (PC+1). Every step is followed by exactly one cycle with all strobes low, so a step without memory takes two cycles.
- R3: A step with `mem_en` high keeps the same strobes until `mem_ready` is high, then completes.
- R4: Opcodes 0001 (ADD), 0101 (AND) and 1001 (NOT) run an evaluate step and a write-back step. Both steps drive `gate_alu` with `alu_fn` 0=ADD, 1=AND, 2=NOT. `sr2_imm` follows IR bit 5 except for NOT. Write-back adds `ld_reg` and `ld_cc` with `dr_sel`=0 (IR[11:9]).
- R5: Loads 0010 and 0110 form the address through the shared adder, with `addr_sel` 0 (PC+offset9) or 1 (base+offset6). They read one operand, then load it into the register with `ld_cc`.
- R6: Indirect opcodes 1010 (load) and 1011 (store) read a pointer first. They move the pointer from MDR to MAR, then access the operand, so memory is accessed twice.
- R7: Stores 0011 and 0111 pass the source register (`sr1_sel`=1, IR[11:9]) through the ALU (`alu_fn`=3) into MDR and make one write (`mem_we`). They assert neither `ld_reg` nor `ld_cc`.
- R8: Opcode 1110 loads PC+offset9 into the register with `ld_cc` and makes no memory access beyond fetch.
- R9: Opcode 0000 samples `br_taken` during decode. When it is high, one step loads the PC with `pc_mux`=2 (adder) and `addr_sel`=0. Otherwise fetch restarts.
- R10: Opcode 1100 loads the PC with `pc_mux`=2 and `addr_sel`=2 (base register plus zero).
- R11: Opcode 1111 writes the PC into R7 (`gate_pc`, `ld_reg`, `dr_sel`=1, no `ld_cc`). It then puts the zero-extended vector into MAR (`addr_sel`=3), reads memory, and loads the PC from the bus (`pc_mux`=1).
- R12: Any other opcode returns to fetch after decode with no `ld_reg`, `ld_cc`, `mem_we` or extra `ld_pc`.
- R13: At most one of the four bus gates is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 4 | IR[15:12] |
| ir_imm | input | 1 | IR[5], immediate operand select |
| br_taken | input | 1 | Branch condition met (from datapath) |
| mem_ready | input | 1 | Memory access completes this cycle |
| gate_pc | output | 1 | PC drives the bus |
| gate_mdr | output | 1 | MDR drives the bus |
| gate_alu | output | 1 | ALU result drives the bus |
| gate_marmux | output | 1 | Address adder drives the bus |
| ld_mar | output | 1 | Load MAR from bus |
| ld_mdr | output | 1 | Load MDR (memory on read, bus otherwise) |
| ld_ir | output | 1 | Load instruction register |
| ld_pc | output | 1 | Load PC from `pc_mux` |
| ld_reg | output | 1 | Write register file |
| ld_cc | output | 1 | Update condition codes |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write (read when low) |
| sr2_imm | output | 1 | ALU second operand is sign-extended imm5 |
| pc_mux | output | 2 | 0 PC+1, 1 bus, 2 adder, 3 start |
| addr_sel | output | 2 | 0 PC+off9, 1 base+off6, 2 base+0, 3 trap vector |
| sr1_sel | output | 1 | 0 IR[8:6], 1 IR[11:9] |
| dr_sel | output | 1 | 0 IR[11:9], 1 R7 |
| alu_fn | output | 2 | 0 ADD, 1 AND, 2 NOT, 3 pass |
| pc_start | output | 16 | Reset start address |

## Verification
The bench checks the step count per opcode. A missing release cycle shortens every instruction, and a missing or extra step changes the count of reads, writes or register loads. It stalls a memory step with `mem_ready` low: a sequencer that ignores the handshake would move on and load a stale MDR. It also checks the case where NOT has its bit 5 set, which must not select the immediate. It checks both branch outcomes, the trap link target, and an opcode with no defined behaviour, which must leave no state written. A reset in the middle of an indirect load must abandon it and restart fetch.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam logic [3:0] OP_BR   = 4'b0000;
  localparam logic [3:0] OP_ADD  = 4'b0001;
  localparam logic [3:0] OP_LD   = 4'b0010;
  localparam logic [3:0] OP_ST   = 4'b0011;
  localparam logic [3:0] OP_AND  = 4'b0101;
  localparam logic [3:0] OP_LDR  = 4'b0110;
  localparam logic [3:0] OP_STR  = 4'b0111;
  localparam logic [3:0] OP_NOT  = 4'b1001;
  localparam logic [3:0] OP_LDI  = 4'b1010;
  localparam logic [3:0] OP_STI  = 4'b1011;
  localparam logic [3:0] OP_JMP  = 4'b1100;
  localparam logic [3:0] OP_LEA  = 4'b1110;
  localparam logic [3:0] OP_TRAP = 4'b1111;

  localparam logic [1:0] PCM_INC   = 2'd0;
  localparam logic [1:0] PCM_BUS   = 2'd1;
  localparam logic [1:0] PCM_ADDR  = 2'd2;
  localparam logic [1:0] PCM_START = 2'd3;

  localparam logic [1:0] ADR_PC9   = 2'd0;
  localparam logic [1:0] ADR_BASE6 = 2'd1;
  localparam logic [1:0] ADR_BASE0 = 2'd2;
  localparam logic [1:0] ADR_TRAP  = 2'd3;

  localparam logic [1:0] ALU_ADD  = 2'd0;
  localparam logic [1:0] ALU_AND  = 2'd1;
  localparam logic [1:0] ALU_NOT  = 2'd2;
  localparam logic [1:0] ALU_PASS = 2'd3;

  typedef enum logic [4:0] {
    S_FETCH_ADDR, S_FETCH_IR, S_DECODE,
    S_ALU_EVAL, S_ALU_WB,
    S_ADDR_EVAL, S_RD_PTR, S_PTR_MAR, S_RD_OPND, S_LD_WB,
    S_ST_DATA, S_WR_MEM,
    S_LEA_WB, S_BR_TAKE, S_JMP,
    S_TRAP_LINK, S_TRAP_VEC, S_TRAP_RD, S_TRAP_PC
  } step_e;

  typedef struct packed {
    logic       gate_pc;
    logic       gate_mdr;
    logic       gate_alu;
    logic       gate_marmux;
    logic       ld_mar;
    logic       ld_mdr;
    logic       ld_ir;
    logic       ld_pc;
    logic       ld_reg;
    logic       ld_cc;
    logic       mem_en;
    logic       mem_we;
    logic       sr2_imm;
    logic [1:0] pc_mux;
    logic [1:0] addr_sel;
    logic       sr1_sel;
    logic       dr_sel;
    logic [1:0] alu_fn;
  } ctrl_t;
endpackage

// File: rtl/seq_step_decode.sv
module seq_step_decode
  import seq_pkg::*;
(
  input  step_e      step_i,
  input  logic [3:0] opcode_i,
  input  logic       imm_i,
  output ctrl_t      ctrl_o
);
  logic [1:0] op_alu;
  logic       base_mode;

  always_comb begin
    case (opcode_i)
      OP_AND:  op_alu = ALU_AND;
      OP_NOT:  op_alu = ALU_NOT;
      default: op_alu = ALU_ADD;
    endcase
    base_mode = (opcode_i == OP_LDR) || (opcode_i == OP_STR);
  end

  always_comb begin
    ctrl_o = '0;
    case (step_i)
      S_FETCH_ADDR: begin
        ctrl_o.gate_pc = 1'b1;
        ctrl_o.ld_mar  = 1'b1;
        ctrl_o.mem_en  = 1'b1;
        ctrl_o.ld_mdr  = 1'b1;
      end
      S_FETCH_IR: begin
        ctrl_o.gate_mdr = 1'b1;
        ctrl_o.ld_ir    = 1'b1;
        ctrl_o.ld_pc    = 1'b1;
        ctrl_o.pc_mux   = PCM_INC;
      end
      S_ALU_EVAL, S_ALU_WB: begin
        ctrl_o.gate_alu = 1'b1;
        ctrl_o.alu_fn   = op_alu;
        ctrl_o.sr2_imm  = imm_i && (opcode_i != OP_NOT);
        if (step_i == S_ALU_WB) begin
          ctrl_o.ld_reg = 1'b1;
          ctrl_o.ld_cc  = 1'b1;
        end
      end
      S_ADDR_EVAL: begin
        ctrl_o.addr_sel    = base_mode ? ADR_BASE6 : ADR_PC9;
        ctrl_o.gate_marmux = 1'b1;
        ctrl_o.ld_mar      = 1'b1;
      end
      S_RD_PTR, S_RD_OPND, S_TRAP_RD: begin
        ctrl_o.mem_en = 1'b1;
        ctrl_o.ld_mdr = 1'b1;
      end
      S_PTR_MAR: begin
        ctrl_o.gate_mdr = 1'b1;
        ctrl_o.ld_mar   = 1'b1;
      end
      S_LD_WB: begin
        ctrl_o.gate_mdr = 1'b1;
        ctrl_o.ld_reg   = 1'b1;
        ctrl_o.ld_cc    = 1'b1;
      end
      S_ST_DATA: begin
        ctrl_o.sr1_sel  = 1'b1;
        ctrl_o.alu_fn   = ALU_PASS;
        ctrl_o.gate_alu = 1'b1;
        ctrl_o.ld_mdr   = 1'b1;
      end
      S_WR_MEM: begin
        ctrl_o.mem_en = 1'b1;
        ctrl_o.mem_we = 1'b1;
      end
      S_LEA_WB: begin
        ctrl_o.addr_sel    = ADR_PC9;
        ctrl_o.gate_marmux = 1'b1;
        ctrl_o.ld_reg      = 1'b1;
        ctrl_o.ld_cc       = 1'b1;
      end
      S_BR_TAKE: begin
        ctrl_o.addr_sel = ADR_PC9;
        ctrl_o.pc_mux   = PCM_ADDR;
        ctrl_o.ld_pc    = 1'b1;
      end
      S_JMP: begin
        ctrl_o.addr_sel = ADR_BASE0;
        ctrl_o.pc_mux   = PCM_ADDR;
        ctrl_o.ld_pc    = 1'b1;
      end
      S_TRAP_LINK: begin
        ctrl_o.gate_pc = 1'b1;
        ctrl_o.dr_sel  = 1'b1;
        ctrl_o.ld_reg  = 1'b1;
      end
      S_TRAP_VEC: begin
        ctrl_o.addr_sel    = ADR_TRAP;
        ctrl_o.gate_marmux = 1'b1;
        ctrl_o.ld_mar      = 1'b1;
      end
      S_TRAP_PC: begin
        ctrl_o.gate_mdr = 1'b1;
        ctrl_o.pc_mux   = PCM_BUS;
        ctrl_o.ld_pc    = 1'b1;
      end
      default: ctrl_o = '0;
    endcase
  end
endmodule

// File: rtl/seq_next_step.sv
module seq_next_step
  import seq_pkg::*;
(
  input  step_e      step_i,
  input  logic [3:0] opcode_i,
  input  logic       br_taken_i,
  output step_e      next_o
);
  logic indirect;
  logic is_store;

  always_comb begin
    indirect = (opcode_i == OP_LDI) || (opcode_i == OP_STI);
    is_store = (opcode_i == OP_ST) || (opcode_i == OP_STR) || (opcode_i == OP_STI);
    next_o   = S_FETCH_ADDR;
    case (step_i)
      S_FETCH_ADDR: next_o = S_FETCH_IR;
      S_FETCH_IR:   next_o = S_DECODE;
      S_DECODE: begin
        case (opcode_i)
          OP_ADD, OP_AND, OP_NOT:                 next_o = S_ALU_EVAL;
          OP_LD, OP_LDR, OP_LDI, OP_ST, OP_STR,
          OP_STI:                                 next_o = S_ADDR_EVAL;
          OP_LEA:                                 next_o = S_LEA_WB;
          OP_BR:   next_o = br_taken_i ? S_BR_TAKE : S_FETCH_ADDR;
          OP_JMP:                                 next_o = S_JMP;
          OP_TRAP:                                next_o = S_TRAP_LINK;
          default:                                next_o = S_FETCH_ADDR;
        endcase
      end
      S_ALU_EVAL:  next_o = S_ALU_WB;
      S_ADDR_EVAL: begin
        if (indirect)      next_o = S_RD_PTR;
        else if (is_store) next_o = S_ST_DATA;
        else               next_o = S_RD_OPND;
      end
      S_RD_PTR:    next_o = S_PTR_MAR;
      S_PTR_MAR:   next_o = is_store ? S_ST_DATA : S_RD_OPND;
      S_RD_OPND:   next_o = S_LD_WB;
      S_ST_DATA:   next_o = S_WR_MEM;
      S_TRAP_LINK: next_o = S_TRAP_VEC;
      S_TRAP_VEC:  next_o = S_TRAP_RD;
      S_TRAP_RD:   next_o = S_TRAP_PC;
      default:     next_o = S_FETCH_ADDR;
    endcase
  end
endmodule

// File: rtl/instr_sequencer.sv
module instr_sequencer
  import seq_pkg::*;
#(
  parameter int               XLEN       = 16,
  parameter logic [XLEN-1:0]  START_ADDR = 16'h3000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [3:0]      opcode,
  input  logic            ir_imm,
  input  logic            br_taken,
  input  logic            mem_ready,
  output logic            gate_pc,
  output logic            gate_mdr,
  output logic            gate_alu,
  output logic            gate_marmux,
  output logic            ld_mar,
  output logic            ld_mdr,
  output logic            ld_ir,
  output logic            ld_pc,
  output logic            ld_reg,
  output logic            ld_cc,
  output logic            mem_en,
  output logic            mem_we,
  output logic            sr2_imm,
  output logic [1:0]      pc_mux,
  output logic [1:0]      addr_sel,
  output logic            sr1_sel,
  output logic            dr_sel,
  output logic [1:0]      alu_fn,
  output logic [XLEN-1:0] pc_start
);
  step_e step_q, step_d;
  logic  gap_q;
  logic  step_done;
  ctrl_t step_ctrl, out_ctrl;

  seq_step_decode u_decode (
    .step_i   (step_q),
    .opcode_i (opcode),
    .imm_i    (ir_imm),
    .ctrl_o   (step_ctrl)
  );

  seq_next_step u_next (
    .step_i     (step_q),
    .opcode_i   (opcode),
    .br_taken_i (br_taken),
    .next_o     (step_d)
  );

  assign step_done = !step_ctrl.mem_en || mem_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= S_FETCH_ADDR;
      gap_q  <= 1'b0;
    end else if (gap_q) begin
      gap_q  <= 1'b0;
    end else if (step_done) begin
      step_q <= step_d;
      gap_q  <= 1'b1;
    end
  end

  always_comb begin
    out_ctrl = step_ctrl;
    if (rst) begin
      out_ctrl        = '0;
      out_ctrl.ld_pc  = 1'b1;
      out_ctrl.pc_mux = PCM_START;
    end else if (gap_q) begin
      out_ctrl = '0;
    end
  end

  assign gate_pc     = out_ctrl.gate_pc;
  assign gate_mdr    = out_ctrl.gate_mdr;
  assign gate_alu    = out_ctrl.gate_alu;
  assign gate_marmux = out_ctrl.gate_marmux;
  assign ld_mar      = out_ctrl.ld_mar;
  assign ld_mdr      = out_ctrl.ld_mdr;
  assign ld_ir       = out_ctrl.ld_ir;
  assign ld_pc       = out_ctrl.ld_pc;
  assign ld_reg      = out_ctrl.ld_reg;
  assign ld_cc       = out_ctrl.ld_cc;
  assign mem_en      = out_ctrl.mem_en;
  assign mem_we      = out_ctrl.mem_we;
  assign sr2_imm     = out_ctrl.sr2_imm;
  assign pc_mux      = out_ctrl.pc_mux;
  assign addr_sel    = out_ctrl.addr_sel;
  assign sr1_sel     = out_ctrl.sr1_sel;
  assign dr_sel      = out_ctrl.dr_sel;
  assign alu_fn      = out_ctrl.alu_fn;
  assign pc_start    = START_ADDR;
endmodule

// File: rtl/seq_checker.sv
module seq_checker (
  input logic       clk,
  input logic       rst,
  input logic       mem_ready,
  input logic       gate_pc,
  input logic       gate_mdr,
  input logic       gate_alu,
  input logic       gate_marmux,
  input logic       ld_mar,
  input logic       ld_mdr,
  input logic       ld_ir,
  input logic       ld_pc,
  input logic       ld_reg,
  input logic       ld_cc,
  input logic       mem_en,
  input logic       mem_we,
  input logic [1:0] pc_mux,
  input logic       dr_sel
);
  logic any_strobe;
  assign any_strobe = gate_pc | gate_mdr | gate_alu | gate_marmux | ld_mar | ld_mdr |
                      ld_ir | ld_pc | ld_reg | ld_cc | mem_en | mem_we;

  a_r1_reset_load: assert property (@(posedge clk)
    rst |-> (ld_pc && pc_mux == 2'd3 && !mem_en && !ld_reg));

  a_r1_first_fetch: assert property (@(posedge clk)
    $fell(rst) |-> (gate_pc && ld_mar && mem_en && !mem_we && ld_mdr));

  a_r2_release: assert property (@(posedge clk) disable iff (rst)
    (any_strobe && (!mem_en || mem_ready)) |=> !any_strobe);

  a_r3_mem_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_en && !mem_ready) |=> (mem_en && $stable({mem_we, ld_mdr, ld_mar, gate_pc})));

  a_r13_one_gate: assert property (@(posedge clk) disable iff (rst)
    $onehot0({gate_pc, gate_mdr, gate_alu, gate_marmux}));

  a_r7_write_clean: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_en && !ld_reg && !ld_cc));

  a_r11_link_from_pc: assert property (@(posedge clk) disable iff (rst)
    (ld_reg && dr_sel) |-> (gate_pc && !ld_cc));
endmodule

bind instr_sequencer seq_checker u_seq_checker (
  .clk         (clk),
  .rst         (rst),
  .mem_ready   (mem_ready),
  .gate_pc     (gate_pc),
  .gate_mdr    (gate_mdr),
  .gate_alu    (gate_alu),
  .gate_marmux (gate_marmux),
  .ld_mar      (ld_mar),
  .ld_mdr      (ld_mdr),
  .ld_ir       (ld_ir),
  .ld_pc       (ld_pc),
  .ld_reg      (ld_reg),
  .ld_cc       (ld_cc),
  .mem_en      (mem_en),
  .mem_we      (mem_we),
  .pc_mux      (pc_mux),
  .dr_sel      (dr_sel)
);

// File: tb/test_instr_sequencer.sv
module test_instr_sequencer;
  localparam int RW = 43;
  localparam int VW = RW + 6;
  localparam int NV = 17;

  // {opcode, ir_imm, br_taken, cycles, reads, writes, ldreg, ldpc, ldcc, sr2, conflicts, dr, pcm, adr, alu}
  localparam logic [VW-1:0] VEC [NV] = '{
    {4'b0001,1'b0,1'b0, 8'd10,4'd1,4'd0,4'd1,4'd1,4'd1,4'd0,4'd0,1'b0,2'd0,2'd0,2'd0},
    {4'b0001,1'b1,1'b0, 8'd10,4'd1,4'd0,4'd1,4'd1,4'd1,4'd2,4'd0,1'b0,2'd0,2'd0,2'd0},
    {4'b0101,1'b0,1'b0, 8'd10,4'd1,4'd0,4'd1,4'd1,4'd1,4'd0,4'd0,1'b0,2'd0,2'd0,2'd1},
    {4'b1001,1'b1,1'b0, 8'd10,4'd1,4'd0,4'd1,4'd1,4'd1,4'd0,4'd0,1'b0,2'd0,2'd0,2'd2},
    {4'b0010,1'b0,1'b0, 8'd12,4'd2,4'd0,4'd1,4'd1,4'd1,4'd0,4'd0,1'b0,2'd0,2'd0,2'd0},
    {4'b0110,1'b0,1'b0, 8'd12,4'd2,4'd0,4'd1,4'd1,4'd1,4'd0,4'd0,1'b0,2'd0,2'd1,2'd0},
    {4'b1010,1'b0,1'b0, 8'd16,4'd3,4'd0,4'd1,4'd1,4'd1,4'd0,4'd0,1'b0,2'd0,2'd0,2'd0},
    {4'b0011,1'b0,1'b0, 8'd12,4'd1,4'd1,4'd0,4'd1,4'd0,4'd0,4'd0,1'b0,2'd0,2'd0,2'd3},
    {4'b0111,1'b0,1'b0, 8'd12,4'd1,4'd1,4'd0,4'd1,4'd0,4'd0,4'd0,1'b0,2'd0,2'd1,2'd3},
    {4'b1011,1'b0,1'b0, 8'd16,4'd2,4'd1,4'd0,4'd1,4'd0,4'd0,4'd0,1'b0,2'd0,2'd0,2'd3},
    {4'b1110,1'b0,1'b0, 8'd8, 4'd1,4'd0,4'd1,4'd1,4'd1,4'd0,4'd0,1'b0,2'd0,2'd0,2'd0},
    {4'b0000,1'b0,1'b1, 8'd8, 4'd1,4'd0,4'd0,4'd2,4'd0,4'd0,4'd0,1'b0,2'd2,2'd0,2'd0},
    {4'b0000,1'b0,1'b0, 8'd6, 4'd1,4'd0,4'd0,4'd1,4'd0,4'd0,4'd0,1'b0,2'd0,2'd0,2'd0},
    {4'b1100,1'b0,1'b0, 8'd8, 4'd1,4'd0,4'd0,4'd2,4'd0,4'd0,4'd0,1'b0,2'd2,2'd2,2'd0},
    {4'b1111,1'b0,1'b0, 8'd14,4'd2,4'd0,4'd1,4'd2,4'd0,4'd0,4'd0,1'b1,2'd1,2'd3,2'd0},
    {4'b1101,1'b0,1'b0, 8'd6, 4'd1,4'd0,4'd0,4'd1,4'd0,4'd0,4'd0,1'b0,2'd0,2'd0,2'd0},
    {4'b1000,1'b1,1'b1, 8'd6, 4'd1,4'd0,4'd0,4'd1,4'd0,4'd0,4'd0,1'b0,2'd0,2'd0,2'd0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  opcode = 4'b0001;
  logic        ir_imm = 1'b0;
  logic        br_taken = 1'b0;
  logic        mem_ready = 1'b0;
  logic        gate_pc, gate_mdr, gate_alu, gate_marmux;
  logic        ld_mar, ld_mdr, ld_ir, ld_pc, ld_reg, ld_cc;
  logic        mem_en, mem_we, sr2_imm, sr1_sel, dr_sel;
  logic [1:0]  pc_mux, addr_sel, alu_fn;
  logic [15:0] pc_start;

  int checks = 0;
  int fails  = 0;

  instr_sequencer i_instr_sequencer (
    .clk(clk), .rst(rst), .opcode(opcode), .ir_imm(ir_imm), .br_taken(br_taken),
    .mem_ready(mem_ready), .gate_pc(gate_pc), .gate_mdr(gate_mdr), .gate_alu(gate_alu),
    .gate_marmux(gate_marmux), .ld_mar(ld_mar), .ld_mdr(ld_mdr), .ld_ir(ld_ir),
    .ld_pc(ld_pc), .ld_reg(ld_reg), .ld_cc(ld_cc), .mem_en(mem_en), .mem_we(mem_we),
    .sr2_imm(sr2_imm), .pc_mux(pc_mux), .addr_sel(addr_sel), .sr1_sel(sr1_sel),
    .dr_sel(dr_sel), .alu_fn(alu_fn), .pc_start(pc_start)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step_tb();
    @(negedge clk);
    #1;
  endtask

  function automatic logic any_on();
    return gate_pc | gate_mdr | gate_alu | gate_marmux | ld_mar | ld_mdr | ld_ir |
           ld_pc | ld_reg | ld_cc | mem_en | mem_we;
  endfunction

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'b0001, 4'b0101, 4'b1001: return "R4";
      4'b0010, 4'b0110:          return "R5";
      4'b1010, 4'b1011:          return "R6";
      4'b0011, 4'b0111:          return "R7";
      4'b1110:                   return "R8";
      4'b0000:                   return "R9";
      4'b1100:                   return "R10";
      4'b1111:                   return "R11";
      default:                   return "R12";
    endcase
  endfunction

  task automatic run_instr(input logic [3:0] op, input logic imm, input logic br,
                           output logic [RW-1:0] res);
    logic [7:0] cyc;
    logic [3:0] rd, wr, lr, lp, lc, s2, cf;
    logic       dr;
    logic [1:0] pcm, adr, alu;
    cyc = '0; rd = '0; wr = '0; lr = '0; lp = '0; lc = '0; s2 = '0; cf = '0;
    dr = 1'b0; pcm = '0; adr = '0; alu = '0;
    opcode = op; ir_imm = imm; br_taken = br; mem_ready = 1'b1;
    for (int g = 0; g < 50 && !(gate_pc && ld_mar); g++) step_tb();
    do begin
      if (mem_en && !mem_we) rd++;
      if (mem_en && mem_we) wr++;
      if (ld_reg) begin lr++; dr = dr_sel; end
      if (ld_pc) begin lp++; pcm = pc_mux; end
      if (ld_cc) lc++;
      if (sr2_imm) s2++;
      if ((gate_pc + gate_mdr + gate_alu + gate_marmux) > 1) cf++;
      if (gate_marmux || (ld_pc && pc_mux == 2'd2)) adr = addr_sel;
      if (gate_alu) alu = alu_fn;
      cyc++;
      step_tb();
    end while (!(gate_pc && ld_mar) && cyc < 8'd60);
    res = {cyc, rd, wr, lr, lp, lc, s2, cf, dr, pcm, adr, alu};
  endtask

  initial begin
    #3000000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [RW-1:0] got;
    repeat (3) step_tb();
    // R1: reset state
    chk("R1 reset ld_pc", {63'd0, ld_pc}, 64'd1);
    chk("R1 reset pc_mux", {62'd0, pc_mux}, 64'd3);
    chk("R1 pc_start", {48'd0, pc_start}, 64'h3000);
    chk("R1 reset quiet", {62'd0, mem_en, ld_reg}, 64'd0);
    rst = 1'b0;
    #1;
    chk("R1 first fetch", {60'd0, gate_pc, ld_mar, mem_en, ld_mdr}, 64'hF);
    // R3: memory wait holds fetch strobes
    for (int w = 0; w < 4; w++) begin
      step_tb();
      chk("R3 hold", {59'd0, gate_pc, ld_mar, mem_en, ld_mdr, mem_we}, 64'h1E);
    end
    mem_ready = 1'b1;
    step_tb();
    chk("R2 release cycle", {63'd0, any_on()}, 64'd0);
    step_tb();
    chk("R2 fetch ir", {59'd0, gate_mdr, ld_ir, ld_pc, pc_mux}, 64'h1C);
    // table walk
    for (int v = 0; v < NV; v++) begin
      run_instr(VEC[v][VW-1 -: 4], VEC[v][RW+1], VEC[v][RW], got);
      chk({tag_of(VEC[v][VW-1 -: 4]), " R2 R13 steps"}, {21'd0, got}, {21'd0, VEC[v][RW-1:0]});
    end
    // R1: reset mid indirect load
    opcode = 4'b1010;
    repeat (7) step_tb();
    rst = 1'b1;
    step_tb();
    chk("R1 mid reset", {61'd0, ld_pc, pc_mux}, 64'h7);
    rst = 1'b0;
    #1;
    chk("R1 restart fetch", {61'd0, gate_pc, ld_mar, ld_reg}, 64'h6);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule